// File: doc/BRIEF.md
# Wakeup Interrupt Controller

This block is a small always-on detector that watches a set of wake sources while a processor sits in deep sleep and its normal interrupt controller is unclocked. A power controller loads a mask of the sources that may wake the core. From then on, every unmasked source that goes high is latched as pending. Any pending bit raises a single wake-up request. The pending and sense vectors are brought out, so surrounding logic can see which sources are armed and which one fired.

Entry to this sleep mode takes two handshakes. The power controller first raises an enable request and waits for the acknowledge. The block passes the request on to the core as an active-low deep-sleep request, and the core answers on an active-low acknowledge. A mask load issued while the enable is acknowledged and the core has answered arms the block. A disable input has two effects. It refuses the enable handshake. If it arrives while the block is armed, it forces the wake-up output high at once and reports a fallback to the ordinary sleep policy.

All pins are plain control and status levels. There is no data stream here, so there is no valid/ready interface and no back-pressure.

Top module: `wake_detect`

## Requirements
- R1: After reset, mask, sense, pending, armed, wake, fallback and enable acknowledge are all 0, and the deep-sleep request (active low) is 1.
- R2: The enable acknowledge is 1 in the cycle after a cycle with enable request 1 and disable 0. Otherwise it is 0 in the next cycle. The deep-sleep request output is always the inverse of the acknowledge.
- R3: While disable is 1, the acknowledge is 0 from the next cycle, and a mask load does not arm the block.
- R4: A load strobe without clear captures the mask input into the mask register, which appears on the sense output in the next cycle. It also zeroes pending and clears fallback. The block is armed after the load only if, in the load cycle, the acknowledge was 1, the core acknowledge (active low) was 0 and disable was 0.
- R5: While armed and with disable 0, a source bit that is 1 and whose mask bit is 1 sets the pending bit at the same position in the next cycle. The pending bit stays set until the next load or clear.
- R6: A source bit whose mask bit is 0 never sets its pending bit.
- R7: The wake output is 1 whenever the block is armed with at least one pending bit set, or fallback is set, or the block is armed while disable is 1.
- R8: Disable at 1 while armed drives wake high in that same cycle. From the next cycle, armed is 0 and fallback is 1, and wake stays 1 until a load or clear.
- R9: A clear strobe zeroes mask, sense and pending, disarms the block and clears fallback in the next cycle. Clear takes priority over a simultaneous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | N_SRC | Wake-source lines, one bit position per source |
| mask_load | input | 1 | Load strobe for the mask |
| mask_in | input | N_SRC | Mask value captured on load |
| clr | input | 1 | Clear strobe |
| en_req | input | 1 | Enable request from the power controller |
| en_ack | output | 1 | Enable acknowledge to the power controller |
| dis | input | 1 | Disable; blocks entry and forces wake when armed |
| ds_req_n | output | 1 | Deep-sleep request to the core, active low |
| ds_ack_n | input | 1 | Deep-sleep acknowledge from the core, active low |
| pend | output | N_SRC | Latched pending wake sources |
| sense | output | N_SRC | Armed-source vector (current mask) |
| armed | output | 1 | Block is armed and watching sources |
| fallback | output | 1 | Sleep policy reverted after a disable |
| wake | output | 1 | Wake-up request |

## Verification
The bench builds the block with four sources. That is small enough that the all-ones mask, single-bit masks and sources that hit only masked-off positions can all be driven on purpose. The random phase then reaches clear and load collisions, disables during arming, and disables that fall in the middle of a sticky pending state. A width of four also leaves room to show a pending bit staying set after its source returns low, while a different bit sets alongside it.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned DEFAULT_SRC = 8;

  typedef enum logic [1:0] {
    POL_IDLE     = 2'd0,
    POL_ARMED    = 2'd1,
    POL_FALLBACK = 2'd2
  } pol_state_e;
endpackage

// File: rtl/wake_latch.sv
module wake_latch #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             capture,
  input  logic [N_SRC-1:0] mask_in,
  input  logic [N_SRC-1:0] src,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (clr)   mask_q <= '0;
    else if (load)  mask_q <= mask_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pend_q[i] <= 1'b0;
      else if (clr || load)                pend_q[i] <= 1'b0;
      else if (capture && src[i] && mask_q[i]) pend_q[i] <= 1'b1;
    end
  end

  // R5: a pending bit is never lost without a load or clear
  a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6: masked-off positions never become pending
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> ((pend_q & ~$past(mask_q) & ~$past(pend_q)) == '0));

  // R9: clear empties both registers
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend_q == '0 && mask_q == '0));
endmodule

// File: rtl/wake_policy.sv
module wake_policy
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis,
  input  logic ds_ack_n,
  input  logic clr,
  input  logic load,
  output logic en_ack,
  output logic armed,
  output logic fallback
);
  pol_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_ack <= 1'b0;
    else        en_ack <= en_req && !dis;
  end

  always_comb begin
    state_d = state_q;
    if (clr)
      state_d = POL_IDLE;
    else if (load)
      state_d = (en_ack && !ds_ack_n && !dis) ? POL_ARMED : POL_IDLE;
    else if (state_q == POL_ARMED && dis)
      state_d = POL_FALLBACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= POL_IDLE;
    else        state_q <= state_d;
  end

  assign armed    = (state_q == POL_ARMED);
  assign fallback = (state_q == POL_FALLBACK);

  // R3: disable refuses the enable handshake
  a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !en_ack);

  // R8: armed and fallback are never both reported
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && fallback));

  // R8: disable while armed leads to fallback unless cleared or reloaded
  a_r8_revert: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dis && !clr && !load) |=> fallback);
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_pkg::*;
#(
  parameter int unsigned N_SRC = DEFAULT_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic             mask_load,
  input  logic [N_SRC-1:0] mask_in,
  input  logic             clr,
  input  logic             en_req,
  output logic             en_ack,
  input  logic             dis,
  output logic             ds_req_n,
  input  logic             ds_ack_n,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] sense,
  output logic             armed,
  output logic             fallback,
  output logic             wake
);
  logic capture;

  wake_policy u_policy (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .dis      (dis),
    .ds_ack_n (ds_ack_n),
    .clr      (clr),
    .load     (mask_load),
    .en_ack   (en_ack),
    .armed    (armed),
    .fallback (fallback)
  );

  assign capture = armed && !dis;

  wake_latch #(.N_SRC(N_SRC)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (mask_load),
    .capture (capture),
    .mask_in (mask_in),
    .src     (src),
    .mask_q  (sense),
    .pend_q  (pend)
  );

  assign ds_req_n = !en_ack;
  assign wake     = (armed && (|pend)) || fallback || (armed && dis);

  // R8: a forced wake is immediate
  a_r8_forced_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dis) |-> wake);

  // R7: nothing pending and no forced cause means no wake
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !fallback && !dis) |-> !wake);

  // R2: request toward the core mirrors the acknowledge
  a_r2_core_req: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_n != en_ack);
endmodule

// File: tb/wake_detect_test.sv
`timescale 1ns/1ps
module wake_detect_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0, mask_in = '0;
  logic         mask_load = 0, clr = 0, en_req = 0, dis = 0, ds_ack_n = 1;
  logic         en_ack, ds_req_n, armed, fallback, wake;
  logic [N-1:0] pend, sense;

  int tests = 0, fails = 0, cycles = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  wake_detect #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .src(src), .mask_load(mask_load), .mask_in(mask_in),
    .clr(clr), .en_req(en_req), .en_ack(en_ack), .dis(dis), .ds_req_n(ds_req_n),
    .ds_ack_n(ds_ack_n), .pend(pend), .sense(sense), .armed(armed),
    .fallback(fallback), .wake(wake)
  );

  // behavioural reference
  bit       m_ack, m_armed, m_fb;
  bit [N-1:0] m_mask, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack = 0; m_armed = 0; m_fb = 0; m_mask = '0; m_pend = '0;
    end else begin
      bit nxt_armed, nxt_fb;
      bit [N-1:0] nxt_mask, nxt_pend;
      nxt_armed = m_armed; nxt_fb = m_fb; nxt_mask = m_mask; nxt_pend = m_pend;
      if (clr) begin
        nxt_armed = 0; nxt_fb = 0; nxt_mask = '0; nxt_pend = '0;
      end else if (mask_load) begin
        nxt_mask = mask_in; nxt_pend = '0; nxt_fb = 0;
        nxt_armed = m_ack && !ds_ack_n && !dis;
      end else if (m_armed && dis) begin
        nxt_armed = 0; nxt_fb = 1;
      end else if (m_armed) begin
        for (int i = 0; i < N; i++)
          if (src[i] && m_mask[i]) nxt_pend[i] = 1;
      end
      m_ack = en_req && !dis;
      m_armed = nxt_armed; m_fb = nxt_fb; m_mask = nxt_mask; m_pend = nxt_pend;
    end
  end

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_wake;
      exp_wake = (m_armed && m_pend != 0) || m_fb || (m_armed && dis);
      chk("en_ack R2", en_ack, m_ack);
      chk("ds_req_n R2", ds_req_n, !m_ack);
      chk("sense R4", sense, m_mask);
      chk("armed R4", armed, m_armed);
      chk("pend R5", pend, m_pend);
      chk("wake R7", wake, exp_wake);
      chk("fallback R8", fallback, m_fb);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_load(logic [N-1:0] m);
    mask_in = m; mask_load = 1; step(); mask_load = 0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    step(2);
    rst_n = 1; #0.5;
    phase = "R1";
    chk("reset wake R1", wake, 0); chk("reset ds_req_n R1", ds_req_n, 1);
    chk("reset pend R1", pend, 0); chk("reset armed R1", armed, 0);
    step();
    phase = "R2"; en_req = 1; step(3); en_req = 0; step(2);
    phase = "R4"; en_req = 1; step(2); ds_ack_n = 0; step(); pulse_load(4'b0101); step();
    chk("armed after load R4", armed, 1); chk("sense R4", sense, 4'b0101);
    phase = "R6"; src = 4'b1010; step(3); src = '0; step();
    chk("masked pend R6", pend, 0);
    phase = "R5"; src = 4'b0001; step(); src = '0; step(3);
    chk("sticky pend R5", pend, 4'b0001); chk("wake R7", wake, 1);
    phase = "R4"; pulse_load(4'b1111);
    chk("reload pend R4", pend, 0);
    phase = "R5"; src = 4'b1000; step(); src = 4'b0100; step(); src = '0; step();
    chk("two bits R5", pend, 4'b1100);
    phase = "R8"; dis = 1; #0.5; chk("immediate wake R8", wake, 1);
    step(); chk("fallback R8", fallback, 1); dis = 0; step(3);
    chk("wake held R8", wake, 1);
    phase = "R9"; clr = 1; mask_in = 4'b0011; mask_load = 1; step(); clr = 0; mask_load = 0;
    chk("clear wins R9", sense, 0); chk("clear wake R9", wake, 0);
    phase = "R3"; dis = 1; step(2); chk("refused ack R3", en_ack, 0);
    pulse_load(4'b0011); chk("not armed R3", armed, 0); dis = 0; step(2);
    phase = "R4"; ds_ack_n = 1; pulse_load(4'b0011); chk("core ack gate R4", armed, 0);
    phase = "RND";
    for (int k = 0; k < 3000; k++) begin
      src       = N'($urandom);
      mask_in   = N'($urandom);
      en_req    = ($urandom % 8) != 0;
      ds_ack_n  = ($urandom % 4) == 0;
      dis       = ($urandom % 20) == 0;
      clr       = ($urandom % 40) == 0;
      mask_load = ($urandom % 12) == 0;
      step();
    end
    src = '0; mask_load = 0; clr = 0; dis = 0; step(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule